// File: doc/BRIEF.md
# Byte and Pair Register Bank with Pointer Addressing

This block keeps the working state of a small 8-bit datapath: six byte registers (a, b, c, d, p, i), an accumulator byte, and a 16-bit stack pointer. A 3-bit operand code selects one byte for reading or writing. A 2-bit pair code selects a 16-bit view for reading or writing. The views are a:b, c:d, p:i and the stack pointer, with the first-named byte in the upper half. One operand code does not name a register. It means "the memory byte whose address is p:i". When that code is used, the block raises a request flag and leaves every register unchanged, so the surrounding sequencer can perform the memory access.

An address port produces a 16-bit memory address from a chosen pair in one of four modes: plain, post-increment, pre-decrement, or pair plus a sign-extended byte displacement. The two stepping modes write the stepped value back into the pair on the same clock edge that uses the address. The memory itself is outside the block.

Top module: `acc_pair_regfile`

## Requirements
- R1: After reset every byte register, the accumulator and the stack pointer read as zero.
- R2: Operand codes 000 to 101 select a, b, c, d, p and i in that order, and 111 selects the accumulator. A byte write changes only the selected register, and a byte read returns the value written by the latest earlier write.
- R3: Reading with operand code 110 sets `rd_mem` to 1 and drives `rd_data` to zero. `op_addr` always equals p in bits 15:8 and i in bits 7:0.
- R4: Writing with operand code 110 sets `wr_mem` to 1 and leaves every register unchanged.
- R5: Pair codes 00, 01, 10 and 11 select a:b, c:d, p:i and the stack pointer. The first-named byte is bits 15:8. A pair write updates both bytes on one edge. The stack pointer can be reached only through a pair code.
- R6: Address mode 00 outputs the pair value on `am_addr` and leaves the pair unchanged.
- R7: Address mode 01 outputs the current pair value, and the pair holds that value plus one after the clock edge.
- R8: Address mode 10 outputs the pair value minus one, and the pair holds that same value after the clock edge.
- R9: Address mode 11 outputs the pair plus `am_disp` sign-extended from bit 7, and leaves the pair unchanged.
- R10: Stepping wraps modulo 2^16: 0xFFFF post-incremented becomes 0x0000, and 0x0000 pre-decremented gives an address and pair of 0xFFFF.
- R11: When several writes reach the same byte in one cycle, the address-mode write-back wins over a pair write, and a pair write wins over a byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_sel | input | 3 | Operand code for the byte read |
| rd_data | output | 8 | Byte read result |
| rd_mem | output | 1 | Read code selects the memory operand |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Operand code for the byte write |
| wr_data | input | 8 | Byte write data |
| wr_mem | output | 1 | Write targets the memory operand |
| op_addr | output | 16 | Memory operand address p:i |
| prd_sel | input | 2 | Pair code for the pair read |
| prd_data | output | 16 | Pair read result |
| pwr_en | input | 1 | Pair write enable |
| pwr_sel | input | 2 | Pair code for the pair write |
| pwr_data | input | 16 | Pair write data |
| am_en | input | 1 | Address generation active (enables write-back) |
| am_pair | input | 2 | Pair code used as the address base |
| am_mode | input | 2 | Address mode |
| am_disp | input | 8 | Signed displacement for mode 11 |
| am_addr | output | 16 | Generated memory address |

## Verification
A corrupted register shows up on the read ports as soon as the register is selected. The read path is combinational, so a bad value is visible in the same cycle as the select. A wrong step or a missed write-back is not visible in the address of the step that caused it; it appears in the pair value one edge later. The bench therefore reads each stepped pair back after the edge, and runs the same pair through several steps in a row so that an error carries forward. Writes to the memory code and plain-mode accesses are checked by reading every register afterwards, which catches any register touched by mistake.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [2:0] {
      OP_A = 3'd0, OP_B = 3'd1, OP_C = 3'd2, OP_D = 3'd3,
      OP_P = 3'd4, OP_I = 3'd5, OP_MEM = 3'd6, OP_ACC = 3'd7
   } op_sel_e;

   typedef enum logic [1:0] {
      PR_AB = 2'd0, PR_CD = 2'd1, PR_PI = 2'd2, PR_SP = 2'd3
   } pair_sel_e;

   typedef enum logic [1:0] {
      AM_DIRECT = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_DISP = 2'd3
   } am_mode_e;

   // storage slots: 0..5 byte regs, 6 unused (memory code), 7 acc, 8/9 sp hi/lo
   localparam int NSLOT    = 10;
   localparam int NPAIR    = 4;
   localparam int SLOT_ACC = 7;
   localparam int SLOT_SPH = 8;
   localparam int SLOT_SPL = 9;
endpackage

// File: rtl/rf_addr_gen.sv
module rf_addr_gen #(
   parameter int W = 8
) (
   input  logic [2*W-1:0] base,
   input  logic [1:0]     mode,
   input  logic [W-1:0]   disp,
   output logic [2*W-1:0] addr,
   output logic           wb,
   output logic [2*W-1:0] wb_val
);
   import rf_pkg::*;
   localparam int AW = 2 * W;

   logic [AW-1:0] inc_v, dec_v, sx_v;

   always_comb begin
      inc_v = base + AW'(1);
      dec_v = base - AW'(1);
      sx_v  = {{W{disp[W-1]}}, disp};
      addr   = base;
      wb     = 1'b0;
      wb_val = base;
      unique case (am_mode_e'(mode))
         AM_DIRECT:  addr = base;
         AM_POSTINC: begin addr = base;  wb = 1'b1; wb_val = inc_v; end
         AM_PREDEC:  begin addr = dec_v; wb = 1'b1; wb_val = dec_v; end
         AM_DISP:    addr = base + sx_v;
         default:    addr = base;
      endcase
   end
endmodule

// File: rtl/rf_byte_cell.sv
module rf_byte_cell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bw_en,
   input  logic [W-1:0] bw_d,
   input  logic         pw_en,
   input  logic [W-1:0] pw_d,
   input  logic         aw_en,
   input  logic [W-1:0] aw_d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (aw_en) q <= aw_d;
      else if (pw_en) q <= pw_d;
      else if (bw_en) q <= bw_d;
   end
endmodule

// File: rtl/acc_pair_regfile.sv
module acc_pair_regfile #(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          rd_sel,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_mem,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                wr_mem,
   output logic [2*DATA_W-1:0] op_addr,
   input  logic [1:0]          prd_sel,
   output logic [2*DATA_W-1:0] prd_data,
   input  logic                pwr_en,
   input  logic [1:0]          pwr_sel,
   input  logic [2*DATA_W-1:0] pwr_data,
   input  logic                am_en,
   input  logic [1:0]          am_pair,
   input  logic [1:0]          am_mode,
   input  logic [DATA_W-1:0]   am_disp,
   output logic [2*DATA_W-1:0] am_addr
);
   import rf_pkg::*;
   localparam int W  = DATA_W;
   localparam int AW = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("acc_pair_regfile: DATA_W must be at least 2");
   end

   logic [W-1:0]  slot_q   [NSLOT];
   logic [AW-1:0] pair_val [NPAIR];
   logic [AW-1:0] ag_addr, ag_wb_val;
   logic          ag_wb, am_wb;

   // pair views: high slot first
   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      localparam int HS = (k < 3) ? 2 * k     : SLOT_SPH;
      localparam int LS = (k < 3) ? 2 * k + 1 : SLOT_SPL;
      assign pair_val[k] = {slot_q[HS], slot_q[LS]};
   end

   rf_addr_gen #(.W(W)) u_agen (
      .base   (pair_val[am_pair]),
      .mode   (am_mode),
      .disp   (am_disp),
      .addr   (ag_addr),
      .wb     (ag_wb),
      .wb_val (ag_wb_val)
   );

   assign am_wb   = am_en && ag_wb;
   assign am_addr = ag_addr;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      if (s == int'(OP_MEM)) begin : g_hole
         assign slot_q[s] = '0;
      end else begin : g_reg
         localparam int          PID = (s < 6) ? s / 2 : 3;
         localparam bit          HI  = (s < 6) ? ((s % 2) == 0) : (s == SLOT_SPH);
         logic         bw, pw, aw;
         logic [W-1:0] pd, ad;

         if (s < 8) begin : g_code
            assign bw = wr_en && (wr_sel == 3'(s));
         end else begin : g_nocode
            assign bw = 1'b0;
         end

         if (s != SLOT_ACC) begin : g_inpair
            assign pw = pwr_en && (pwr_sel == 2'(PID));
            assign aw = am_wb  && (am_pair == 2'(PID));
            assign pd = HI ? pwr_data[AW-1:W]  : pwr_data[W-1:0];
            assign ad = HI ? ag_wb_val[AW-1:W] : ag_wb_val[W-1:0];
         end else begin : g_solo
            assign pw = 1'b0;
            assign aw = 1'b0;
            assign pd = '0;
            assign ad = '0;
         end

         rf_byte_cell #(.W(W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .bw_en (bw),
            .bw_d  (wr_data),
            .pw_en (pw),
            .pw_d  (pd),
            .aw_en (aw),
            .aw_d  (ad),
            .q     (slot_q[s])
         );
      end
   end

   assign rd_mem   = (op_sel_e'(rd_sel) == OP_MEM);
   assign rd_data  = rd_mem ? '0 : slot_q[rd_sel];
   assign wr_mem   = wr_en && (op_sel_e'(wr_sel) == OP_MEM);
   assign op_addr  = pair_val[PR_PI];
   assign prd_data = pair_val[prd_sel];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       wr_sel,
   input logic             pwr_en,
   input logic             am_en,
   input logic [1:0]       am_pair,
   input logic [1:0]       am_mode,
   input logic [W-1:0]     am_disp,
   input logic [2*W-1:0]   am_addr,
   input logic [1:0]       prd_sel,
   input logic [2*W-1:0]   prd_data,
   input logic [9*W-1:0]   state
);
   localparam int AW = 2 * W;

   p_memwr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'b110 && !pwr_en && !am_en) |=> $stable(state));

   p_direct_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (am_en && am_mode == 2'b00 && !pwr_en && !wr_en) |=> $stable(state));

   p_postinc_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (am_en && am_mode == 2'b01 && prd_sel == am_pair) |-> am_addr == prd_data);

   p_postinc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (am_en && am_mode == 2'b01 && prd_sel == am_pair) ##1 (prd_sel == $past(prd_sel))
      |-> prd_data == AW'($past(prd_data) + AW'(1)));

   p_predec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (am_en && am_mode == 2'b10 && prd_sel == am_pair) ##1 (prd_sel == $past(prd_sel))
      |-> prd_data == $past(am_addr));

   p_disp_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (am_en && am_mode == 2'b11 && prd_sel == am_pair)
      |-> am_addr == AW'(prd_data + {{W{am_disp[W-1]}}, am_disp}));
endmodule

bind acc_pair_regfile rf_checker #(.W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .pwr_en   (pwr_en),
   .am_en    (am_en),
   .am_pair  (am_pair),
   .am_mode  (am_mode),
   .am_disp  (am_disp),
   .am_addr  (am_addr),
   .prd_sel  (prd_sel),
   .prd_data (prd_data),
   .state    ({pair_val[0], pair_val[1], pair_val[2], pair_val[3], slot_q[7]})
);

// File: tb/acc_pair_regfile_tb.sv
`timescale 1ns/1ps
module acc_pair_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rd_sel = '0;
   logic [7:0]  rd_data;
   logic        rd_mem;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_mem;
   logic [15:0] op_addr;
   logic [1:0]  prd_sel = '0;
   logic [15:0] prd_data;
   logic        pwr_en = 1'b0;
   logic [1:0]  pwr_sel = '0;
   logic [15:0] pwr_data = '0;
   logic        am_en = 1'b0;
   logic [1:0]  am_pair = '0;
   logic [1:0]  am_mode = '0;
   logic [7:0]  am_disp = '0;
   logic [15:0] am_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   acc_pair_regfile u_dut (.*);

   // {wsel, wdata, rsel, expected rd_data, expected rd_mem}
   localparam logic [22:0] VEC [10] = '{
      {3'd0, 8'h11, 3'd0, 8'h11, 1'b0},
      {3'd1, 8'h22, 3'd1, 8'h22, 1'b0},
      {3'd2, 8'h33, 3'd2, 8'h33, 1'b0},
      {3'd3, 8'h44, 3'd3, 8'h44, 1'b0},
      {3'd4, 8'h55, 3'd4, 8'h55, 1'b0},
      {3'd5, 8'h66, 3'd5, 8'h66, 1'b0},
      {3'd7, 8'h77, 3'd7, 8'h77, 1'b0},
      {3'd6, 8'h99, 3'd6, 8'h00, 1'b1},
      {3'd0, 8'hA5, 3'd1, 8'h22, 1'b0},
      {3'd7, 8'h01, 3'd0, 8'hA5, 1'b0}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; pwr_en = 1'b0; am_en = 1'b0;
   endtask

   task automatic pread(input logic [1:0] sel, input logic [15:0] exp, input string tag);
      prd_sel = sel; #1;
      chk(tag, prd_data, exp);
   endtask

   task automatic pwrite(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk); pwr_en = 1'b1; pwr_sel = sel; pwr_data = d;
      @(negedge clk); idle();
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 8; s++) begin
         if (s != 6) begin rd_sel = 3'(s); #1; chk("R1 byte reset", 16'(rd_data), 16'h0); end
      end
      for (int k = 0; k < 4; k++) pread(2'(k), 16'h0, "R1 pair reset");
      rst_n = 1'b1;

      // R2/R3/R4 table walk
      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_sel = VEC[v][22:20]; wr_data = VEC[v][19:12];
         #1;
         if (VEC[v][22:20] == 3'd6) chk("R4 wr_mem flag", 16'(wr_mem), 16'h1);
         @(negedge clk); idle();
         rd_sel = VEC[v][11:9]; #1;
         chk("R2 R3 byte read", 16'(rd_data), 16'(VEC[v][8:1]));
         chk("R3 rd_mem flag", 16'(rd_mem), 16'(VEC[v][0]));
      end
      // R4: memory write left everything intact; R5 pair views high-first
      pread(2'd0, 16'hA522, "R4 R5 pair ab");
      pread(2'd1, 16'h3344, "R4 R5 pair cd");
      pread(2'd2, 16'h5566, "R4 R5 pair pi");
      pread(2'd3, 16'h0000, "R4 R5 sp untouched");
      rd_sel = 3'd7; #1; chk("R4 acc", 16'(rd_data), 16'h0001);
      chk("R3 op_addr", op_addr, 16'h5566);

      // R5 pair writes
      pwrite(2'd3, 16'h1234);
      pread(2'd3, 16'h1234, "R5 sp write");
      pwrite(2'd1, 16'hBEEF);
      rd_sel = 3'd2; #1; chk("R5 c high byte", 16'(rd_data), 16'h00BE);
      rd_sel = 3'd3; #1; chk("R5 d low byte", 16'(rd_data), 16'h00EF);

      // R6 direct
      @(negedge clk); am_en = 1'b1; am_pair = 2'd1; am_mode = 2'd0; #1;
      chk("R6 direct addr", am_addr, 16'hBEEF);
      @(negedge clk); idle();
      pread(2'd1, 16'hBEEF, "R6 pair unchanged");

      // R7 post-increment
      @(negedge clk); am_en = 1'b1; am_pair = 2'd3; am_mode = 2'd1; #1;
      chk("R7 postinc addr", am_addr, 16'h1234);
      @(negedge clk); idle();
      pread(2'd3, 16'h1235, "R7 postinc writeback");

      // R8 pre-decrement
      @(negedge clk); am_en = 1'b1; am_pair = 2'd3; am_mode = 2'd2; #1;
      chk("R8 predec addr", am_addr, 16'h1234);
      @(negedge clk); idle();
      pread(2'd3, 16'h1234, "R8 predec writeback");

      // R9 displacement
      @(negedge clk); am_en = 1'b1; am_pair = 2'd1; am_mode = 2'd3; am_disp = 8'hF0; #1;
      chk("R9 negative disp", am_addr, 16'hBEDF);
      am_disp = 8'h7F; #1;
      chk("R9 positive disp", am_addr, 16'hBF6E);
      @(negedge clk); idle();
      pread(2'd1, 16'hBEEF, "R9 pair unchanged");

      // R10 wrap
      pwrite(2'd0, 16'hFFFF);
      @(negedge clk); am_en = 1'b1; am_pair = 2'd0; am_mode = 2'd1;
      @(negedge clk); idle();
      pread(2'd0, 16'h0000, "R10 increment wrap");
      @(negedge clk); am_en = 1'b1; am_pair = 2'd0; am_mode = 2'd2; #1;
      chk("R10 decrement wrap addr", am_addr, 16'hFFFF);
      @(negedge clk); idle();
      pread(2'd0, 16'hFFFF, "R10 decrement wrap pair");

      // R11 priority
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h12;
      pwr_en = 1'b1; pwr_sel = 2'd0; pwr_data = 16'h3456;
      am_en = 1'b1; am_pair = 2'd0; am_mode = 2'd1;
      @(negedge clk); idle();
      pread(2'd0, 16'h0000, "R11 writeback beats pair write");
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h12;
      pwr_en = 1'b1; pwr_sel = 2'd0; pwr_data = 16'h3456;
      @(negedge clk); idle();
      pread(2'd0, 16'h3456, "R11 pair write beats byte write");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule